// File: doc/BRIEF.md
# Transmit Frame Status Classifier

This block sits beside a transmit packet stream that moves a fixed number of bytes per beat, with the first byte of each beat in the most significant lane. It watches only the beats that are actually accepted, where valid and ready are both high. From the first beat of each frame it decodes the Ethernet header. Across all beats it accumulates the byte count. When the last beat is accepted, it produces one status record for the frame.

The record is a 40-bit word and a 7-bit error vector, both qualified by a single-cycle valid pulse. The word holds:
- the destination address class;
- MAC control, pause and priority flow control flags;
- single or stacked VLAN flags;
- the frame length and the payload length.

The error vector flags oversized frames and mismatches between the length field and the payload. The block never alters the stream. The whole parsed header (up to 24 bytes) must arrive in the first beat, so the beat must be at least 24 bytes wide.

Top module: `tfs_status_classifier`

## Requirements
- R1: Exactly one cycle after a beat with in_valid, in_ready and in_eop all high, stat_valid is high for one cycle. It is never high at any other time, so there is one record per frame.
- R2: stat_word bit 36 is set when all six destination bytes are 0xFF. Bit 37 is set when bit 0 of destination byte 0 is 1 and the address is not all ones. Bit 38 is set when that bit is 0.
- R3: Let T1 be the 16-bit field at frame bytes 12-13 and T2 the field at bytes 16-17. Bit 32 (stacked VLAN) is set when T1 is 0x88A8, or when T1 and T2 are both 0x8100; the frame then has 2 tags. Otherwise, bit 33 (single VLAN) is set when T1 is 0x8100, and the frame has 1 tag.
- R4: The length/type field sits at bytes 12+4·tags, and the 16-bit opcode follows it. Bit 34 is set when that field is 0x8808. Within such frames, bit 35 flags opcode 0x0001 and bit 39 flags opcode 0x0101.
- R5: stat_word[31:16] equals the accepted frame bytes plus 4. Each beat carries BEAT_BYTES bytes, except the EOP beat, which carries BEAT_BYTES minus in_empty. Byte 0 is in lane in_data[DATA_W-1 -: 8].
- R6: stat_word[15:0] equals the accepted frame bytes minus (14 + 4·tags), floored at zero.
- R7: stat_err[1] is set when the frame length of R5 exceeds MAX_UNTAGGED + 4·tags (1518, 1522 or 1526 by default).
- R8: stat_err[2] is set when the length/type field is 1500 or less and differs from the payload length of R6. A field below 46 with a payload of exactly 46 counts as valid padding and is not flagged.
- R9: stat_err bits 0 and 6:3 are always zero in a record.
- R10: Beats presented while in_ready is low, and any cycle with in_valid low, leave the record unchanged, whatever the data, SOP, EOP and empty values are.
- R11: During reset and in the first cycle after it, stat_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Stream beat valid |
| in_ready | input | 1 | Sink ready; a beat is taken when both valid and ready are high |
| in_sop | input | 1 | First beat of a frame |
| in_eop | input | 1 | Last beat of a frame |
| in_empty | input | EMPTY_W | Unused byte lanes in the EOP beat |
| in_data | input | DATA_W | Beat data, first byte in the top lane |
| stat_valid | output | 1 | One-cycle record qualifier |
| stat_word | output | 40 | Frame type flags and lengths |
| stat_err | output | 7 | Error vector |

## Verification
The bench builds the block with a 32-byte beat and the default 1518-byte untagged limit. With the narrower beat, a full-sized frame spans about fifty beats, so cross-beat accumulation and every value of in_empty on the last beat come up often. The header still fits in the first beat. The lengths tried sit on both sides of each oversize threshold and the 1500 length/type boundary. Stalled beats carry deliberately corrupted data, so any beat taken while ready is low shows up as a wrong record.

// File: rtl/tfs_pkg.sv
package tfs_pkg;
    localparam logic [15:0] TPID_CUST      = 16'h8100;
    localparam logic [15:0] TPID_SVC       = 16'h88A8;
    localparam logic [15:0] ETYPE_MAC_CTRL = 16'h8808;
    localparam logic [15:0] OPC_PAUSE      = 16'h0001;
    localparam logic [15:0] OPC_PRIO       = 16'h0101;
    localparam int BASE_HDR      = 14;
    localparam int TAG_BYTES     = 4;
    localparam int FCS_BYTES     = 4;
    localparam int MIN_PAYLOAD   = 46;
    localparam int MAX_LEN_FIELD = 1500;
    localparam int PARSE_BYTES   = 24;
    localparam int LEN_W         = 16;

    typedef logic [LEN_W-1:0] len_t;

    typedef struct packed {
        logic        bcast;
        logic        mcast;
        logic        ucast;
        logic [1:0]  tags;
        logic        ctrl;
        logic        pause;
        logic        pfc;
        logic [15:0] lentype;
    } hdr_t;

    typedef struct packed {
        logic pfc;
        logic ucast;
        logic mcast;
        logic bcast;
        logic pause;
        logic ctrl;
        logic vlan1;
        logic vlan2;
        len_t frame_len;
        len_t payload_len;
    } status_t;

    typedef struct packed {
        logic [3:0] rsv_hi;
        logic       len_err;
        logic       oversize;
        logic       rsv_lo;
    } err_t;

    function automatic len_t hdr_len(input logic [1:0] tags);
        return len_t'(BASE_HDR + TAG_BYTES * int'(tags));
    endfunction

    function automatic len_t sat_add(input len_t a, input len_t b);
        logic [LEN_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[LEN_W] ? '1 : s[LEN_W-1:0];
    endfunction
endpackage

// File: rtl/tfs_hdr_parse.sv
module tfs_hdr_parse
    import tfs_pkg::*;
#(
    parameter int BEAT_BYTES = 64
) (
    input  logic [BEAT_BYTES*8-1:0] beat,
    output hdr_t                    hdr
);
    logic [7:0] hb [PARSE_BYTES];

    for (genvar g = 0; g < PARSE_BYTES; g++) begin : g_lane
        assign hb[g] = beat[(BEAT_BYTES-1-g)*8 +: 8];
    end

    logic [15:0] tp_a, tp_b, opc;
    logic        dst_ones;

    always_comb begin
        tp_a     = {hb[12], hb[13]};
        tp_b     = {hb[16], hb[17]};
        dst_ones = &{hb[0], hb[1], hb[2], hb[3], hb[4], hb[5]};
        hdr       = '0;
        hdr.bcast = dst_ones;
        hdr.mcast = hb[0][0] & ~dst_ones;
        hdr.ucast = ~hb[0][0];
        if (tp_a == TPID_SVC || (tp_a == TPID_CUST && tp_b == TPID_CUST)) begin
            hdr.tags    = 2'd2;
            hdr.lentype = {hb[20], hb[21]};
            opc         = {hb[22], hb[23]};
        end else if (tp_a == TPID_CUST) begin
            hdr.tags    = 2'd1;
            hdr.lentype = {hb[16], hb[17]};
            opc         = {hb[18], hb[19]};
        end else begin
            hdr.tags    = 2'd0;
            hdr.lentype = tp_a;
            opc         = {hb[14], hb[15]};
        end
        hdr.ctrl  = (hdr.lentype == ETYPE_MAC_CTRL);
        hdr.pause = hdr.ctrl && (opc == OPC_PAUSE);
        hdr.pfc   = hdr.ctrl && (opc == OPC_PRIO);
    end
endmodule

// File: rtl/tfs_len_count.sv
module tfs_len_count
    import tfs_pkg::*;
#(
    parameter int BEAT_BYTES = 64,
    parameter int EMPTY_W    = $clog2(BEAT_BYTES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               take,
    input  logic               sop,
    input  logic               eop,
    input  logic [EMPTY_W-1:0] empty,
    output len_t               total
);
    len_t acc_q, beat_cnt, base;

    always_comb begin
        beat_cnt = len_t'(BEAT_BYTES) - (eop ? len_t'(empty) : '0);
        base     = sop ? '0 : acc_q;
        total    = sat_add(base, beat_cnt);
    end

    always_ff @(posedge clk) begin
        if (rst)       acc_q <= '0;
        else if (take) acc_q <= total;
    end
endmodule

// File: rtl/tfs_status_classifier.sv
module tfs_status_classifier
    import tfs_pkg::*;
#(
    parameter int BEAT_BYTES   = 64,
    parameter int MAX_UNTAGGED = 1518,
    localparam int DATA_W      = BEAT_BYTES * 8,
    localparam int EMPTY_W     = $clog2(BEAT_BYTES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               in_ready,
    input  logic               in_sop,
    input  logic               in_eop,
    input  logic [EMPTY_W-1:0] in_empty,
    input  logic [DATA_W-1:0]  in_data,
    output logic               stat_valid,
    output logic [39:0]        stat_word,
    output logic [6:0]         stat_err
);
    logic    take;
    hdr_t    hdr_now, hdr_q, hdr_use;
    len_t    total, hlen, pay, flen, limit;
    status_t st_d, st_q;
    err_t    er_d, er_q;

    assign take = in_valid & in_ready;

    tfs_hdr_parse #(.BEAT_BYTES(BEAT_BYTES)) u_parse (
        .beat (in_data),
        .hdr  (hdr_now)
    );

    tfs_len_count #(.BEAT_BYTES(BEAT_BYTES), .EMPTY_W(EMPTY_W)) u_count (
        .clk   (clk),
        .rst   (rst),
        .take  (take),
        .sop   (in_sop),
        .eop   (in_eop),
        .empty (in_empty),
        .total (total)
    );

    always_ff @(posedge clk) begin
        if (rst)                hdr_q <= '0;
        else if (take && in_sop) hdr_q <= hdr_now;
    end

    always_comb begin
        hdr_use = in_sop ? hdr_now : hdr_q;
        hlen    = hdr_len(hdr_use.tags);
        flen    = sat_add(total, len_t'(FCS_BYTES));
        pay     = (total > hlen) ? total - hlen : '0;
        limit   = len_t'(MAX_UNTAGGED) + len_t'(TAG_BYTES * int'(hdr_use.tags));

        st_d.pfc         = hdr_use.pfc;
        st_d.ucast       = hdr_use.ucast;
        st_d.mcast       = hdr_use.mcast;
        st_d.bcast       = hdr_use.bcast;
        st_d.pause       = hdr_use.pause;
        st_d.ctrl        = hdr_use.ctrl;
        st_d.vlan1       = (hdr_use.tags == 2'd1);
        st_d.vlan2       = (hdr_use.tags == 2'd2);
        st_d.frame_len   = flen;
        st_d.payload_len = pay;

        er_d          = '0;
        er_d.oversize = (flen > limit);
        er_d.len_err  = (hdr_use.lentype <= 16'(MAX_LEN_FIELD))
                     && (pay != hdr_use.lentype)
                     && !((hdr_use.lentype < 16'(MIN_PAYLOAD)) && (pay == len_t'(MIN_PAYLOAD)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_valid <= 1'b0;
            st_q       <= '0;
            er_q       <= '0;
        end else begin
            stat_valid <= take & in_eop;
            if (take && in_eop) begin
                st_q <= st_d;
                er_q <= er_d;
            end
        end
    end

    assign stat_word = st_q;
    assign stat_err  = er_q;

    // R1
    valid_after_eop_chk: assert property (@(posedge clk) disable iff (rst)
        stat_valid |-> $past(in_valid && in_ready && in_eop));

    // R2
    addr_class_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        stat_valid |-> $countones(stat_word[38:36]) == 1);

    // R3
    vlan_excl_chk: assert property (@(posedge clk) disable iff (rst)
        stat_valid |-> $onehot0(stat_word[33:32]));

    // R4
    ctrl_subtype_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_valid && (stat_word[39] || stat_word[35])) |-> stat_word[34]);

    // R5
    frame_exceeds_payload_chk: assert property (@(posedge clk) disable iff (rst)
        stat_valid |-> stat_word[31:16] > stat_word[15:0]);

    // R7
    oversize_floor_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_valid && stat_err[1]) |-> stat_word[31:16] > len_t'(MAX_UNTAGGED));
endmodule

// File: tb/tfs_status_classifier_test.sv
`timescale 1ns/1ps
module tfs_status_classifier_test;
    localparam int BB = 32;
    localparam int EW = $clog2(BB);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0, in_ready = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [EW-1:0] in_empty = '0;
    logic [BB*8-1:0] in_data = '0;
    logic          stat_valid;
    logic [39:0]   stat_word;
    logic [6:0]    stat_err;

    always #4 clk = ~clk;

    tfs_status_classifier #(.BEAT_BYTES(BB), .MAX_UNTAGGED(1518)) uut (
        .clk, .rst, .in_valid, .in_ready, .in_sop, .in_eop, .in_empty, .in_data,
        .stat_valid, .stat_word, .stat_err
    );

    int checks = 0, errors = 0;
    bit finished = 0;
    logic [7:0]  fb [0:2047];
    logic [39:0] exp_w [0:1023];
    logic [6:0]  exp_e [0:1023];
    int wr_i = 0, rd_i = 0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model(input int n);
        bit bc, mc, uc, ctrl, pa, pf, over, lerr;
        int t1, t2, tags, h, lt, op, pay, fl;
        bc = 1;
        for (int k = 0; k < 6; k++) if (fb[k] != 8'hFF) bc = 0;
        mc = fb[0][0] && !bc;
        uc = !fb[0][0];
        t1 = int'({fb[12], fb[13]});
        t2 = int'({fb[16], fb[17]});
        if (t1 == 'h88A8 || (t1 == 'h8100 && t2 == 'h8100)) tags = 2;
        else if (t1 == 'h8100) tags = 1;
        else tags = 0;
        h    = 14 + 4 * tags;
        lt   = int'({fb[h-2], fb[h-1]});
        op   = int'({fb[h], fb[h+1]});
        ctrl = (lt == 'h8808);
        pa   = ctrl && op == 1;
        pf   = ctrl && op == 'h101;
        pay  = (n > h) ? n - h : 0;
        fl   = n + 4;
        over = fl > 1518 + 4 * tags;
        lerr = lt <= 1500 && pay != lt && !(lt < 46 && pay == 46);
        exp_w[wr_i] = {pf, uc, mc, bc, pa, ctrl, tags == 1, tags == 2, 16'(fl), 16'(pay)};
        exp_e[wr_i] = {4'b0, lerr, over, 1'b0};
        wr_i++;
    endtask

    task automatic build(input int addr_k, input int tag_k, input int lt_val,
                         input int op_val, input int pay, output int n);
        int pos;
        for (int k = 0; k < 12; k++) fb[k] = 8'($urandom);
        case (addr_k)
            0: fb[0][0] = 1'b0;
            1: begin fb[0][0] = 1'b1; fb[1] = 8'h00; end
            default: for (int k = 0; k < 6; k++) fb[k] = 8'hFF;
        endcase
        pos = 12;
        if (tag_k == 1) begin
            fb[12] = 8'h81; fb[13] = 8'h00; fb[14] = 8'($urandom); fb[15] = 8'($urandom); pos = 16;
        end else if (tag_k >= 2) begin
            fb[12] = (tag_k == 2) ? 8'h88 : 8'h81; fb[13] = (tag_k == 2) ? 8'hA8 : 8'h00;
            fb[14] = 8'($urandom); fb[15] = 8'($urandom);
            fb[16] = 8'h81; fb[17] = 8'h00; fb[18] = 8'($urandom); fb[19] = 8'($urandom); pos = 20;
        end
        fb[pos]   = 8'(lt_val >> 8);
        fb[pos+1] = 8'(lt_val);
        for (int k = 0; k < pay; k++) fb[pos+2+k] = 8'($urandom);
        if (lt_val == 'h8808) begin
            fb[pos+2] = 8'(op_val >> 8);
            fb[pos+3] = 8'(op_val);
        end
        n = pos + 2 + pay;
    endtask

    task automatic send(input int n, input int stall_pct);
        int nb;
        nb = (n + BB - 1) / BB;
        model(n);
        for (int b = 0; b < nb; b++) begin
            bit acc;
            acc = 0;
            while (!acc) begin
                @(negedge clk);
                if (int'($urandom_range(99)) < stall_pct) begin
                    in_valid = 1'b1; in_ready = 1'b0;
                    in_sop = 1'($urandom); in_eop = 1'($urandom);
                    in_empty = EW'($urandom); in_data = {BB/4{$urandom}};
                end else begin
                    for (int k = 0; k < BB; k++)
                        in_data[(BB-1-k)*8 +: 8] = (b*BB + k < n) ? fb[b*BB + k] : 8'($urandom);
                    in_sop   = (b == 0);
                    in_eop   = (b == nb - 1);
                    in_empty = (b == nb - 1) ? EW'(nb*BB - n) : '0;
                    in_valid = 1'b1; in_ready = 1'b1;
                    acc = 1;
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_ready = 1'($urandom);
        in_sop = 1'($urandom); in_eop = 1'($urandom); in_data = {BB/4{$urandom}};
    endtask

    always @(negedge clk) begin
        if (!rst && stat_valid && !finished) begin
            if (rd_i >= wr_i) begin
                checks++; errors++;
                $display("FAIL R1 unexpected record actual=1 expected=0");
            end else begin
                check("R2 address class", stat_word[38:36], exp_w[rd_i][38:36]);
                check("R3 vlan flags", stat_word[33:32], exp_w[rd_i][33:32]);
                check("R4 control flags", {stat_word[39], stat_word[35], stat_word[34]},
                      {exp_w[rd_i][39], exp_w[rd_i][35], exp_w[rd_i][34]});
                check("R5/R10 frame length", stat_word[31:16], exp_w[rd_i][31:16]);
                check("R6 payload length", stat_word[15:0], exp_w[rd_i][15:0]);
                check("R7 oversize", stat_err[1], exp_e[rd_i][1]);
                check("R8 length error", stat_err[2], exp_e[rd_i][2]);
                check("R9 reserved bits", {stat_err[6:3], stat_err[0]}, 5'd0);
                rd_i++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL R1 watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n, seed_val;
        seed_val = int'($urandom(32'd20240));
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R11 valid in reset", stat_valid, 0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check("R11 valid after reset", stat_valid, 0);

        build(2, 0, 'h8808, 'h0001, 46, n); send(n, 0);   // R4 pause, broadcast
        build(1, 1, 'h8808, 'h0101, 46, n); send(n, 0);   // R4 PFC, single tag
        build(0, 0, 'h8808, 'h0002, 46, n); send(n, 0);   // R4 other opcode
        build(0, 2, 'h0800, 0, 100, n);     send(n, 0);   // R3 S-tag stacked
        build(1, 3, 'h86DD, 0, 60, n);      send(n, 0);   // R3 repeated C-tag
        build(0, 0, 100, 0, 100, n);        send(n, 0);   // R8 matching length
        build(0, 0, 20, 0, 46, n);          send(n, 0);   // R8 padded, no error
        build(0, 0, 20, 0, 50, n);          send(n, 0);   // R8 mismatch
        build(0, 0, 500, 0, 499, n);        send(n, 0);   // R8 mismatch
        build(0, 0, 1500, 0, 10, n);        send(n, 0);   // R8 boundary 1500
        build(0, 0, 1501, 0, 10, n);        send(n, 0);   // R8 type, no error
        for (int t = 0; t < 3; t++) begin                 // R7 thresholds
            build(0, (t == 2) ? 2 : t, 'h0800, 0, 1500, n); send(n, 20);
            build(0, (t == 2) ? 2 : t, 'h0800, 0, 1501, n); send(n, 20);
        end

        for (int i = 0; i < 300; i++) begin
            int a, tg, sel, pay, lt, op;
            a   = int'($urandom_range(2));
            tg  = int'($urandom_range(3));
            sel = int'($urandom_range(4));
            pay = ($urandom_range(9) == 0) ? int'($urandom_range(1510, 1490))
                                           : int'($urandom_range(120, 2));
            op  = 0;
            case (sel)
                0: lt = (pay <= 1500) ? pay : 'h0800;
                1: lt = int'($urandom_range(1500, 1));
                2: lt = 'h0800;
                3: begin
                    lt = 'h8808;
                    case ($urandom_range(2))
                        0: op = 1;
                        1: op = 'h101;
                        default: op = 2;
                    endcase
                end
                default: begin lt = int'($urandom_range(45, 1)); pay = 46; end
            endcase
            build(a, tg, lt, op, pay, n);
            send(n, 30);                                  // R10 stalls with garbage
        end

        repeat (4) @(negedge clk);
        check("R1 records per frame", 64'(rd_i), 64'(wr_i));
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule